// File: doc/BRIEF.md
# Interrupt Pin Servicer with Remote-Request Tracking

This block sits between a bank of interrupt input pins and the processor-side interrupt controller. It holds one routing entry per pin, applies that entry's polarity to the raw pin level, and keeps a request bit and a remote-request flag for every pin. When a pin needs service and its entry is unmasked, the block issues a delivery request. The request carries the entry's destination, vector, destination mode, trigger kind and delivery mode. Deliveries leave on a valid/ready stream one at a time, and the lowest-numbered pending pin goes first.

Edge-triggered pins deliver once per rising effective edge. Level-triggered pins set their remote-request flag when a delivery is accepted. They stay blocked until an end-of-interrupt (EOI) arrives whose vector matches the entry, or until the entry is rewritten. After that they deliver again if the line is still asserted. Entries are written through a plain one-cycle write port. EOIs arrive on a plain strobe with a vector and a kind bit.

Back-pressure rules on the delivery stream:
- Once `dlv_valid` rises, it and the whole payload hold steady until a cycle with `dlv_ready` high.
- A delivery counts as successful only in that handshake cycle.
- The payload is captured from the entry when the request is offered, so a later entry write does not alter an offer already on the stream.

Top module: `irq_pin_servicer`

## Requirements
- R1: The effective level of a pin is `pin_level[i]` XOR `cfg_active_low` of its entry. For a level-triggered entry (`cfg_level`=1), `req_bits[i]` equals the effective level one clock after it is sampled, and it reads 0 whenever the effective level is low.
- R2: An edge-triggered entry (`cfg_level`=0) makes exactly one service attempt per rising effective level. Its request bit is high for one cycle and then drops, whether or not a delivery followed. A line held high brings no further deliveries.
- R3: A masked entry (`cfg_mask`=1) never starts a delivery. An edge attempt made while masked is discarded and is not delivered on a later unmask. A level pin still asserted when it is unmasked is delivered.
- R4: When a level-triggered delivery is accepted, `rirr_bits[i]` becomes 1. While that flag is set, the pin offers no further delivery.
- R5: A level-kind EOI (`eoi_valid`=1, `eoi_level`=1) clears the remote flag of every level-triggered pin whose entry vector equals `eoi_vector`, and it leaves non-matching pins alone. A cleared pin that is still asserted and unmasked is delivered again. A pin whose line has dropped is not delivered again.
- R6: A write to a pin's entry clears that pin's remote flag, so a still-asserted level pin is serviced again. A write with `cfg_mask`=1 cancels an attempt of that pin that has not yet been offered.
- R7: The payload carries the pin index, destination, vector, destination mode and trigger kind from the entry. `dlv_mode_word` holds the delivery mode in bits [10:8] with zeros below, `dlv_asserted` is 1 and `dlv_shorthand` is 0.
- R8: When several pins are pending, the lowest-numbered pin is offered first, and only one request is outstanding at a time.
- R9: While `dlv_valid` is high and `dlv_ready` is low, `dlv_valid` and every payload field stay unchanged in the next cycle. No delivery counts as done before the handshake.
- R10: After reset, `dlv_valid`, `req_bits` and `rirr_bits` are 0 and every entry is masked.
- R11: An edge-kind EOI (`eoi_level`=0) leaves every remote flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | NPINS | Raw interrupt line levels |
| cfg_we | input | 1 | Entry write strobe |
| cfg_pin | input | PIN_W | Entry index to write |
| cfg_dest | input | DEST_W | Destination field |
| cfg_vector | input | VEC_W | Vector field |
| cfg_dmode | input | DMODE_W | Delivery mode field |
| cfg_logical | input | 1 | Destination mode, 1 = logical |
| cfg_level | input | 1 | Trigger kind, 1 = level |
| cfg_active_low | input | 1 | Polarity, 1 = active low |
| cfg_mask | input | 1 | Mask, 1 = masked |
| eoi_valid | input | 1 | EOI strobe |
| eoi_vector | input | VEC_W | EOI vector |
| eoi_level | input | 1 | EOI kind, 1 = level |
| dlv_valid | output | 1 | Delivery request offered |
| dlv_ready | input | 1 | Downstream accepts the request |
| dlv_pin | output | PIN_W | Source pin index |
| dlv_dest | output | DEST_W | Destination |
| dlv_vector | output | VEC_W | Vector |
| dlv_logical | output | 1 | Destination mode |
| dlv_level | output | 1 | Trigger kind |
| dlv_mode_word | output | DMODE_W+8 | Delivery mode shifted left by 8 |
| dlv_asserted | output | 1 | Always 1 |
| dlv_shorthand | output | 2 | Always 0 |
| req_bits | output | NPINS | Per-pin request bits |
| rirr_bits | output | NPINS | Per-pin remote-request flags |

## Verification
The assertions accept any `dlv_ready` pattern and any timing of EOIs and entry writes. The check that a level handshake sets the remote flag leaves out a cycle where the same pin's entry is written, because that write takes priority. The bench drives every input on the falling edge, so the block samples stable values. Directed phases exercise each rule on chosen pins. A random phase then toggles lines, ready, entry writes and EOIs, with vectors drawn from a small set so that EOI matches and multi-pin clears happen often.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;
  parameter int VEC_W      = 8;
  parameter int DEST_W     = 8;
  parameter int DMODE_W    = 3;
  parameter int MODE_SHIFT = 8;

  typedef struct packed {
    logic [DEST_W-1:0]  dest;
    logic [VEC_W-1:0]   vector;
    logic [DMODE_W-1:0] dmode;
    logic               logical_dest;
    logic               level;
    logic               active_low;
    logic               masked;
  } redir_t;

  localparam redir_t REDIR_RESET = '{dest: '0, vector: '0, dmode: '0,
                                     logical_dest: 1'b0, level: 1'b0,
                                     active_low: 1'b0, masked: 1'b1};
endpackage

// File: rtl/irq_entry_table.sv
module irq_entry_table
  import irq_svc_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int PIN_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [PIN_W-1:0]       wr_pin,
  input  redir_t                 wr_entry,
  output redir_t [NPINS-1:0]     entries
);
  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entries[g] <= REDIR_RESET;
      else if (wr_en && wr_pin == PIN_W'(g))
        entries[g] <= wr_entry;
    end
  end
endmodule

// File: rtl/irq_pin_slice.sv
module irq_pin_slice
  import irq_svc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_raw,
  input  redir_t           entry,
  input  logic             wr_hit,
  input  logic             wr_masks,
  input  logic             eoi_valid,
  input  logic             eoi_level,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic             loaded,
  input  logic             inflight,
  input  logic             accept_level,
  output logic             req,
  output logic             rirr,
  output logic             pend
);
  logic eff, eff_q;
  logic edge_go, level_go, eoi_hit;
  logic pend_d, rirr_d;

  assign eff = pin_raw ^ entry.active_low;

  // edge request bit is a one-cycle pulse: consumed by the attempt it causes
  assign edge_go  = req & ~entry.level & ~entry.masked;
  assign level_go = req & entry.level & ~entry.masked & ~rirr & ~pend & ~inflight;
  assign eoi_hit  = eoi_valid & eoi_level & entry.level & (entry.vector == eoi_vector);

  always_comb begin
    pend_d = pend;
    if (loaded)              pend_d = 1'b0;
    if (edge_go || level_go) pend_d = 1'b1;
    if (wr_hit && wr_masks)  pend_d = 1'b0;
  end

  always_comb begin
    rirr_d = rirr;
    if (accept_level)  rirr_d = 1'b1;
    else if (eoi_hit)  rirr_d = 1'b0;
    if (wr_hit)        rirr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q <= 1'b0;
      req   <= 1'b0;
      pend  <= 1'b0;
      rirr  <= 1'b0;
    end else begin
      eff_q <= eff;
      req   <= entry.level ? eff : (eff & ~eff_q);
      pend  <= pend_d;
      rirr  <= rirr_d;
    end
  end
endmodule

// File: rtl/irq_deliver_arb.sv
module irq_deliver_arb
  import irq_svc_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int PIN_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   pend,
  input  redir_t [NPINS-1:0] entries,
  input  logic               dlv_ready,
  output logic [NPINS-1:0]   load,
  output logic               out_valid,
  output logic [PIN_W-1:0]   out_pin,
  output redir_t             out_entry,
  output logic               accept
);
  localparam int EW = $bits(redir_t);

  logic [NPINS:0]     seen;
  logic [NPINS-1:0]   grant;
  logic               take;
  logic [PIN_W-1:0]   pick_pin;
  logic [EW-1:0]      pick_bits;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < NPINS; g++) begin : g_pri
    assign grant[g]  = pend[g] & ~seen[g];
    assign seen[g+1] = seen[g] | pend[g];
  end

  assign take   = ~out_valid & seen[NPINS];
  assign load   = grant & {NPINS{take}};
  assign accept = out_valid & dlv_ready;

  always_comb begin
    pick_pin  = '0;
    pick_bits = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (grant[i]) begin
        pick_pin  = pick_pin | PIN_W'(i);
        pick_bits = pick_bits | EW'(entries[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pin   <= '0;
      out_entry <= REDIR_RESET;
    end else if (accept) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_pin   <= pick_pin;
      out_entry <= redir_t'(pick_bits);
    end
  end
endmodule

// File: rtl/irq_pin_servicer.sv
module irq_pin_servicer
  import irq_svc_pkg::*;
#(
  parameter int NPINS = 8,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPINS-1:0]              pin_level,
  input  logic                          cfg_we,
  input  logic [PIN_W-1:0]              cfg_pin,
  input  logic [DEST_W-1:0]             cfg_dest,
  input  logic [VEC_W-1:0]              cfg_vector,
  input  logic [DMODE_W-1:0]            cfg_dmode,
  input  logic                          cfg_logical,
  input  logic                          cfg_level,
  input  logic                          cfg_active_low,
  input  logic                          cfg_mask,
  input  logic                          eoi_valid,
  input  logic [VEC_W-1:0]              eoi_vector,
  input  logic                          eoi_level,
  output logic                          dlv_valid,
  input  logic                          dlv_ready,
  output logic [PIN_W-1:0]              dlv_pin,
  output logic [DEST_W-1:0]             dlv_dest,
  output logic [VEC_W-1:0]              dlv_vector,
  output logic                          dlv_logical,
  output logic                          dlv_level,
  output logic [DMODE_W+MODE_SHIFT-1:0] dlv_mode_word,
  output logic                          dlv_asserted,
  output logic [1:0]                    dlv_shorthand,
  output logic [NPINS-1:0]              req_bits,
  output logic [NPINS-1:0]              rirr_bits
);
  redir_t [NPINS-1:0] entries;
  redir_t             wr_entry;
  redir_t             out_entry;
  logic [NPINS-1:0]   pend, load;
  logic               out_valid, accept;
  logic [PIN_W-1:0]   out_pin;

  assign wr_entry = '{dest: cfg_dest, vector: cfg_vector, dmode: cfg_dmode,
                      logical_dest: cfg_logical, level: cfg_level,
                      active_low: cfg_active_low, masked: cfg_mask};

  irq_entry_table #(.NPINS(NPINS), .PIN_W(PIN_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_pin   (cfg_pin),
    .wr_entry (wr_entry),
    .entries  (entries)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic here;
    assign here = (out_pin == PIN_W'(g));
    irq_pin_slice u_slice (
      .clk          (clk),
      .rst_n        (rst_n),
      .pin_raw      (pin_level[g]),
      .entry        (entries[g]),
      .wr_hit       (cfg_we && cfg_pin == PIN_W'(g)),
      .wr_masks     (cfg_mask),
      .eoi_valid    (eoi_valid),
      .eoi_level    (eoi_level),
      .eoi_vector   (eoi_vector),
      .loaded       (load[g]),
      .inflight     (out_valid & here),
      .accept_level (accept & here & out_entry.level),
      .req          (req_bits[g]),
      .rirr         (rirr_bits[g]),
      .pend         (pend[g])
    );
  end

  irq_deliver_arb #(.NPINS(NPINS), .PIN_W(PIN_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .entries   (entries),
    .dlv_ready (dlv_ready),
    .load      (load),
    .out_valid (out_valid),
    .out_pin   (out_pin),
    .out_entry (out_entry),
    .accept    (accept)
  );

  assign dlv_valid     = out_valid;
  assign dlv_pin       = out_pin;
  assign dlv_dest      = out_entry.dest;
  assign dlv_vector    = out_entry.vector;
  assign dlv_logical   = out_entry.logical_dest;
  assign dlv_level     = out_entry.level;
  assign dlv_mode_word = {out_entry.dmode, {MODE_SHIFT{1'b0}}};
  assign dlv_asserted  = 1'b1;
  assign dlv_shorthand = 2'b00;
endmodule

// File: rtl/irq_pin_servicer_chk.sv
module irq_pin_servicer_chk
  import irq_svc_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int PIN_W = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cfg_we,
  input logic [PIN_W-1:0]              cfg_pin,
  input logic                          dlv_valid,
  input logic                          dlv_ready,
  input logic [PIN_W-1:0]              dlv_pin,
  input logic [DEST_W-1:0]             dlv_dest,
  input logic [VEC_W-1:0]              dlv_vector,
  input logic                          dlv_logical,
  input logic                          dlv_level,
  input logic [DMODE_W+MODE_SHIFT-1:0] dlv_mode_word,
  input logic                          dlv_asserted,
  input logic [1:0]                    dlv_shorthand,
  input logic [NPINS-1:0]              rirr_bits
);
  // R9: offer holds until taken
  p_hold_offer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_pin) && $stable(dlv_dest)
      && $stable(dlv_vector) && $stable(dlv_logical) && $stable(dlv_level)
      && $stable(dlv_mode_word)));

  // R7: fixed payload fields
  p_fixed_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (dlv_asserted && dlv_shorthand == 2'b00
      && dlv_mode_word[MODE_SHIFT-1:0] == '0));

  // R4: accepted level delivery raises the remote flag
  p_rirr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_ready && dlv_level && !(cfg_we && cfg_pin == dlv_pin))
      |=> rirr_bits[$past(dlv_pin)]);

  // R4: no level offer from a pin that is still blocked
  p_level_unblocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_level) |-> !rirr_bits[dlv_pin]);

  // R10: state right after reset release
  p_reset_state_r10: assert property (@(posedge clk)
    $rose(rst_n) |-> (!dlv_valid && rirr_bits == '0));
endmodule

bind irq_pin_servicer irq_pin_servicer_chk #(.NPINS(NPINS), .PIN_W(PIN_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_we        (cfg_we),
  .cfg_pin       (cfg_pin),
  .dlv_valid     (dlv_valid),
  .dlv_ready     (dlv_ready),
  .dlv_pin       (dlv_pin),
  .dlv_dest      (dlv_dest),
  .dlv_vector    (dlv_vector),
  .dlv_logical   (dlv_logical),
  .dlv_level     (dlv_level),
  .dlv_mode_word (dlv_mode_word),
  .dlv_asserted  (dlv_asserted),
  .dlv_shorthand (dlv_shorthand),
  .rirr_bits     (rirr_bits)
);

// File: tb/tb_irq_pin_servicer.sv
`timescale 1ns/1ps
module tb_irq_pin_servicer;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NP-1:0] pin_level = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_pin = '0;
  logic [7:0]  cfg_dest = '0, cfg_vector = '0;
  logic [2:0]  cfg_dmode = '0;
  logic        cfg_logical = 1'b0, cfg_level = 1'b0, cfg_active_low = 1'b0, cfg_mask = 1'b1;
  logic        eoi_valid = 1'b0, eoi_level = 1'b0;
  logic [7:0]  eoi_vector = '0;
  logic        dlv_ready = 1'b1;
  logic        dlv_valid, dlv_logical, dlv_level, dlv_asserted;
  logic [2:0]  dlv_pin;
  logic [7:0]  dlv_dest, dlv_vector;
  logic [10:0] dlv_mode_word;
  logic [1:0]  dlv_shorthand;
  logic [NP-1:0] req_bits, rirr_bits;

  always #2.5 clk = ~clk;

  irq_pin_servicer #(.NPINS(NP)) dut (.*);

  int total = 0, fails = 0;
  bit done = 0, cmp_en = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int e_dest[NP], e_vec[NP], e_dm[NP], e_lg[NP], e_lv[NP], e_al[NP], e_mk[NP];
  int m_effq[NP], m_req[NP], m_rirr[NP], m_pend[NP];
  int m_ov, m_opin, m_odest, m_ovec, m_olg, m_olv, m_odm;
  int dcount[NP];
  int lp_dest, lp_vec, lp_lg, lp_lv, lp_dm;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        e_dest[i] = 0; e_vec[i] = 0; e_dm[i] = 0; e_lg[i] = 0; e_lv[i] = 0;
        e_al[i] = 0; e_mk[i] = 1; m_effq[i] = 0; m_req[i] = 0; m_rirr[i] = 0;
        m_pend[i] = 0; dcount[i] = 0;
      end
      m_ov = 0; m_opin = 0; m_odest = 0; m_ovec = 0; m_olg = 0; m_olv = 0; m_odm = 0;
    end else begin
      int n_req[NP], n_pend[NP], n_rirr[NP], n_eff[NP];
      int hs, pick;
      hs = (m_ov != 0) && dlv_ready;
      pick = -1;
      if (!m_ov)
        for (int i = NP - 1; i >= 0; i--) if (m_pend[i]) pick = i;
      for (int i = 0; i < NP; i++) begin
        int go;
        n_eff[i] = pin_level[i] ^ e_al[i];
        n_req[i] = e_lv[i] ? n_eff[i] : (n_eff[i] && !m_effq[i]);
        if (e_lv[i])
          go = m_req[i] && !e_mk[i] && !m_rirr[i] && !m_pend[i] && !(m_ov && m_opin == i);
        else
          go = m_req[i] && !e_mk[i];
        n_pend[i] = (pick == i) ? 0 : m_pend[i];
        if (go) n_pend[i] = 1;
        n_rirr[i] = m_rirr[i];
        if (hs && m_opin == i && m_olv) n_rirr[i] = 1;
        else if (eoi_valid && eoi_level && e_lv[i] && e_vec[i] == eoi_vector) n_rirr[i] = 0;
        if (cfg_we && cfg_pin == i) begin
          n_rirr[i] = 0;
          if (cfg_mask) n_pend[i] = 0;
        end
      end
      if (hs) begin
        dcount[m_opin]++;
        lp_dest = m_odest; lp_vec = m_ovec; lp_lg = m_olg; lp_lv = m_olv; lp_dm = m_odm;
        m_ov = 0;
      end else if (pick >= 0) begin
        m_ov = 1; m_opin = pick; m_odest = e_dest[pick]; m_ovec = e_vec[pick];
        m_olg = e_lg[pick]; m_olv = e_lv[pick]; m_odm = e_dm[pick];
      end
      if (cfg_we) begin
        e_dest[cfg_pin] = cfg_dest; e_vec[cfg_pin] = cfg_vector; e_dm[cfg_pin] = cfg_dmode;
        e_lg[cfg_pin] = cfg_logical; e_lv[cfg_pin] = cfg_level;
        e_al[cfg_pin] = cfg_active_low; e_mk[cfg_pin] = cfg_mask;
      end
      for (int i = 0; i < NP; i++) begin
        m_effq[i] = n_eff[i]; m_req[i] = n_req[i]; m_pend[i] = n_pend[i]; m_rirr[i] = n_rirr[i];
      end
    end
  end

  // per-cycle comparison, one ns after the active edge
  always @(posedge clk) begin
    #1;
    if (rst_n && cmp_en && !done) begin
      chk("R9", "dlv_valid", dlv_valid, m_ov);
      if (m_ov) begin
        chk("R8", "dlv_pin", dlv_pin, m_opin);
        chk("R7", "dlv_dest", dlv_dest, m_odest);
        chk("R7", "dlv_vector", dlv_vector, m_ovec);
        chk("R7", "dlv_logical", dlv_logical, m_olg);
        chk("R7", "dlv_level", dlv_level, m_olv);
        chk("R7", "dlv_mode_word", dlv_mode_word, m_odm << 8);
        chk("R7", "dlv_asserted", dlv_asserted, 1);
        chk("R7", "dlv_shorthand", dlv_shorthand, 0);
      end
      for (int i = 0; i < NP; i++) begin
        chk("R1", $sformatf("req_bits[%0d]", i), req_bits[i], m_req[i]);
        chk("R4", $sformatf("rirr_bits[%0d]", i), rirr_bits[i], m_rirr[i]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int p, input int dest, input int vec, input int dm,
                    input int lg, input int lv, input int al, input int mk);
    @(negedge clk);
    cfg_we = 1; cfg_pin = 3'(p); cfg_dest = 8'(dest); cfg_vector = 8'(vec);
    cfg_dmode = 3'(dm); cfg_logical = 1'(lg); cfg_level = 1'(lv);
    cfg_active_low = 1'(al); cfg_mask = 1'(mk);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic eoi(input int vec, input int lv);
    @(negedge clk);
    eoi_valid = 1; eoi_vector = 8'(vec); eoi_level = 1'(lv);
    @(negedge clk);
    eoi_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R10: reset state at the ports
    chk("R10", "dlv_valid after reset", dlv_valid, 0);
    chk("R10", "req_bits after reset", req_bits, 0);
    chk("R10", "rirr_bits after reset", rirr_bits, 0);
    cmp_en = 1;

    // R2 / R7: edge pin 3, held high, delivered once
    wr(3, 'h5A, 'h33, 5, 1, 0, 0, 0);
    pin_level[3] = 1; cyc(12);
    chk("R2", "edge pin3 deliveries", dcount[3], 1);
    chk("R2", "edge pin3 req dropped", req_bits[3], 0);
    chk("R7", "last dest", lp_dest, 'h5A);
    chk("R7", "last vector", lp_vec, 'h33);
    chk("R7", "last mode shifted", lp_dm << 8, 'h500);
    chk("R7", "last logical", lp_lg, 1);
    pin_level[3] = 0; cyc(3);

    // R1: active-low edge pin 4
    pin_level[4] = 1; cyc(2);
    wr(4, 'h11, 'h44, 1, 0, 0, 1, 0);
    cyc(6);
    chk("R1", "active-low idle no delivery", dcount[4], 0);
    pin_level[4] = 0; cyc(10);
    chk("R1", "active-low falling line delivers", dcount[4], 1);

    // R3: masked edge is discarded
    wr(5, 'h01, 'h55, 0, 0, 0, 0, 1);
    pin_level[5] = 1; cyc(8);
    wr(5, 'h01, 'h55, 0, 0, 0, 0, 0);
    cyc(10);
    chk("R3", "masked edge discarded", dcount[5], 0);
    pin_level[5] = 0;

    // R3 / R4: masked level pin 2 delivers on unmask, then blocks
    wr(2, 'h22, 'h22, 2, 0, 1, 0, 1);
    pin_level[2] = 1; cyc(10);
    chk("R3", "masked level no delivery", dcount[2], 0);
    chk("R1", "level req follows line", req_bits[2], 1);
    wr(2, 'h22, 'h22, 2, 0, 1, 0, 0);
    cyc(10);
    chk("R3", "unmasked level delivered", dcount[2], 1);
    chk("R4", "remote flag set", rirr_bits[2], 1);
    cyc(20);
    chk("R4", "blocked while remote flag set", dcount[2], 1);

    // R11 then R5
    eoi('h22, 0); cyc(10);
    chk("R11", "edge-kind EOI keeps flag", rirr_bits[2], 1);
    chk("R11", "edge-kind EOI no redelivery", dcount[2], 1);
    eoi('h22, 1); cyc(10);
    chk("R5", "level EOI redelivers", dcount[2], 2);

    // R6: rewrite clears flag, pin re-serviced
    wr(2, 'h22, 'h22, 2, 0, 1, 0, 0);
    cyc(10);
    chk("R6", "rewrite re-services", dcount[2], 3);

    // R8 / R9: two level pins with a shared vector under stall
    dlv_ready = 0;
    wr(6, 'h66, 'h66, 3, 1, 1, 0, 0);
    wr(7, 'h77, 'h66, 4, 0, 1, 0, 0);
    pin_level[6] = 1; pin_level[7] = 1; cyc(10);
    chk("R8", "lowest pin offered first", dlv_pin, 6);
    chk("R9", "offer held under stall", dlv_valid, 1);
    chk("R9", "no delivery before handshake", dcount[6] + dcount[7], 0);
    dlv_ready = 1; cyc(10);
    chk("R8", "pin6 delivered", dcount[6], 1);
    chk("R8", "pin7 delivered", dcount[7], 1);
    eoi('h66, 1); cyc(12);
    chk("R5", "shared vector pin6 again", dcount[6], 2);
    chk("R5", "shared vector pin7 again", dcount[7], 2);
    chk("R5", "non-matching pin2 untouched", dcount[2], 3);

    // R5: dropped line not redelivered after EOI
    pin_level[2] = 0; cyc(4);
    eoi('h22, 1); cyc(10);
    chk("R5", "dropped line no redelivery", dcount[2], 3);
    chk("R5", "flag cleared", rirr_bits[2], 0);

    // R6: masking write cancels an attempt not yet offered
    dlv_ready = 0;
    pin_level[3] = 1; cyc(3); pin_level[3] = 0; cyc(3);
    pin_level[3] = 1; cyc(3); pin_level[3] = 0; cyc(2);
    wr(3, 'h5A, 'h33, 5, 1, 0, 0, 1);
    dlv_ready = 1; cyc(10);
    chk("R6", "masking write cancels queued attempt", dcount[3], 2);

    // random phase, compared cycle by cycle
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      cfg_we = 0; eoi_valid = 0;
      if ($urandom_range(0, 5) == 0) pin_level = NP'($urandom);
      dlv_ready = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 15) == 0) begin
        cfg_we = 1; cfg_pin = 3'($urandom); cfg_dest = 8'($urandom);
        cfg_vector = 8'('h40 + $urandom_range(0, 2)); cfg_dmode = 3'($urandom);
        cfg_logical = 1'($urandom); cfg_level = 1'($urandom);
        cfg_active_low = 1'($urandom); cfg_mask = ($urandom_range(0, 3) == 0);
      end
      if ($urandom_range(0, 7) == 0) begin
        eoi_valid = 1; eoi_vector = 8'('h40 + $urandom_range(0, 2));
        eoi_level = ($urandom_range(0, 3) != 0);
      end
    end
    @(negedge clk);
    cfg_we = 0; eoi_valid = 0;
    cyc(5);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule